// File: doc/BRIEF.md
# PCI Memory Window Address Translator

This block sits between a host bus and a PCI bridge and turns host addresses into PCI memory-space addresses. Three fixed host-side windows are decoded. Each window has a 32-bit remap register, and that register supplies the upper part of the PCI address for accesses that fall in the window. The path from a host address to a PCI address is purely combinational. It uses the remap registers as they stand in the current cycle.

A build-time parameter picks one of two board variants, and that choice sets both the window geometry and the way the remap register is read. In the nibble variant, bits 3:0 of the remap register become PCI address bits 31:28. The windows start at 0x44000000, 0x50000000 and 0x60000000 and have sizes 0x0C000000, 0x10000000 and 0x10000000. In the mask variant, the remap register is ANDed with the inverse of (window size - 1). The windows start at 0x63000000, 0x64000000 and 0x68000000 and have sizes 0x01000000, 0x04000000 and 0x08000000. In both variants the PCI address is the resulting base plus the offset of the host address inside its window.

Top module: `pci_mem_window_xlat`

## Requirements
- R1: A host address hits window i exactly when host base(i) <= address < host base(i) + size(i). The hit flag then asserts and the window index output shows i. Windows never overlap, so at most one window hits.
- R2: An address that hits no window drives the hit flag low, the window index to 0 and the PCI address to 0.
- R3: In the nibble variant, a hit in window i gives PCI address = (remap[i] << 28) + (address - host base(i)), truncated to 32 bits.
- R4: In the mask variant, a hit in window i gives PCI address = (remap[i] & ~(size(i) - 1)) + (address - host base(i)).
- R5: The remap register for window i sits at config byte address 4*i, and the register index is the config address shifted right by 2. Byte address 0xC holds no register: a write there changes no register, and a read there returns 0.
- R6: A config write to register i changes only window i's translation. The change applies from the first cycle after the write's clock edge. In the write cycle itself, the old mapping is still in use.
- R7: Reset clears all three remap registers to 0, so right after reset every window maps to the PCI address equal to its offset within the window.
- R8: The config read data returns the full 32-bit value last written to the addressed remap register, in either variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 4 | Config byte address (register index = addr >> 2) |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Combinational readback of the addressed register |
| host_addr | input | 32 | Host bus address to translate |
| host_hit | output | 1 | Address falls inside one of the windows |
| host_win | output | 2 | Index of the window hit (0 on a miss) |
| pci_addr | output | 32 | Translated PCI memory address (0 on a miss) |

## Verification
A remap write and a translation through the same window can fall in one cycle. In that case the translation must still use the old mapping, and the new mapping must appear in the next cycle. The bench drives a write to window 1 together with a host address in window 1, then repeats the same address without a write. It compares the PCI address against a reference model that updates its register copy only at the clock edge. Random traffic then mixes writes, including writes to the empty slot, with translations every cycle, and the model judges every cycle.

// File: rtl/pcimw_pkg.sv
`timescale 1ns/1ps
package pcimw_pkg;
  localparam int unsigned NWIN = 3;
  localparam int unsigned AW   = 32;

  typedef enum logic {MAP_NIBBLE = 1'b0, MAP_MASK = 1'b1} map_mode_e;

  // Host-side start address of window i for a given variant.
  function automatic logic [AW-1:0] win_host_base(map_mode_e m, int unsigned i);
    logic [AW-1:0] r;
    if (m == MAP_NIBBLE) begin
      case (i)
        0:       r = 32'h4400_0000;
        1:       r = 32'h5000_0000;
        default: r = 32'h6000_0000;
      endcase
    end else begin
      case (i)
        0:       r = 32'h6300_0000;
        1:       r = 32'h6400_0000;
        default: r = 32'h6800_0000;
      endcase
    end
    return r;
  endfunction

  // Span in bytes of window i for a given variant.
  function automatic logic [AW-1:0] win_size(map_mode_e m, int unsigned i);
    logic [AW-1:0] r;
    if (m == MAP_NIBBLE) begin
      case (i)
        0:       r = 32'h0C00_0000;
        default: r = 32'h1000_0000;
      endcase
    end else begin
      case (i)
        0:       r = 32'h0100_0000;
        1:       r = 32'h0400_0000;
        default: r = 32'h0800_0000;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/pcimw_remap_regs.sv
`timescale 1ns/1ps
module pcimw_remap_regs #(
  parameter int unsigned NWIN = 3,
  parameter int unsigned DW   = 32,
  parameter int unsigned RAW  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [RAW-1:0]            addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic [NWIN-1:0][DW-1:0]   remap
);
  logic [RAW-1:0]  idx;
  logic [NWIN-1:0] sel;

  assign idx = addr >> 2;

  always_comb begin
    for (int i = 0; i < NWIN; i++) sel[i] = (idx == RAW'(i));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NWIN; i++) if (sel[i]) rdata = remap[i];
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] nxt;

    always_comb begin
      en  = we && sel[g];
      nxt = en ? wdata : remap[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  remap[g] <= '0;
      else if (en) remap[g] <= nxt;
    end

    // R6: a write to this slot lands on the next edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == RAW'(g)) |=> (remap[g] == $past(wdata)));
    // R6: no write to this slot leaves it untouched
    a_r6_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == RAW'(g)) |=> $stable(remap[g]));
  end

  // R5: the empty slot reads back zero
  a_r5_empty_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= RAW'(NWIN)) |-> (rdata == '0));
endmodule

// File: rtl/pcimw_hit_decode.sv
`timescale 1ns/1ps
module pcimw_hit_decode
  import pcimw_pkg::*;
#(
  parameter map_mode_e MODE = MAP_NIBBLE
) (
  input  logic [AW-1:0]             host_addr,
  output logic [NWIN-1:0]           hit_vec,
  output logic [NWIN-1:0][AW-1:0]   offs
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [AW-1:0] HBASE = win_host_base(MODE, g);
    localparam logic [AW-1:0] HSIZE = win_size(MODE, g);
    // Unsigned wrap makes addresses below the base land far above the size.
    always_comb begin
      offs[g]    = host_addr - HBASE;
      hit_vec[g] = (offs[g] < HSIZE);
    end
  end
endmodule

// File: rtl/pcimw_addr_form.sv
`timescale 1ns/1ps
module pcimw_addr_form
  import pcimw_pkg::*;
#(
  parameter map_mode_e MODE = MAP_NIBBLE,
  parameter int unsigned WW = 2
) (
  input  logic [NWIN-1:0][AW-1:0]   remap,
  input  logic [NWIN-1:0]           hit_vec,
  input  logic [NWIN-1:0][AW-1:0]   offs,
  output logic                      hit,
  output logic [WW-1:0]             win,
  output logic [AW-1:0]             pci_addr
);
  logic [NWIN-1:0][AW-1:0] pbase;

  for (genvar g = 0; g < NWIN; g++) begin : g_base
    localparam logic [AW-1:0] HSIZE = win_size(MODE, g);
    if (MODE == MAP_MASK) begin : g_mask
      assign pbase[g] = remap[g] & ~(HSIZE - 1);
    end else begin : g_nib
      assign pbase[g] = remap[g] << 28;
    end
  end

  // Lowest index wins; windows do not overlap so this only fixes the order.
  always_comb begin
    hit      = 1'b0;
    win      = '0;
    pci_addr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit      = 1'b1;
        win      = WW'(i);
        pci_addr = pbase[i] + offs[i];
      end
    end
  end
endmodule

// File: rtl/pci_mem_window_xlat.sv
`timescale 1ns/1ps
module pci_mem_window_xlat
  import pcimw_pkg::*;
#(
  parameter map_mode_e   MODE = MAP_NIBBLE,
  parameter int unsigned RAW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [31:0]     host_addr,
  output logic            host_hit,
  output logic [1:0]      host_win,
  output logic [31:0]     pci_addr
);
  localparam int unsigned WW = $clog2(NWIN);

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  logic [NWIN-1:0][AW-1:0] remap;
  logic [NWIN-1:0]         hit_vec;
  logic [NWIN-1:0][AW-1:0] offs;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pcimw_remap_regs #(.NWIN(NWIN), .DW(AW), .RAW(RAW)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .remap (remap)
  );

  pcimw_hit_decode #(.MODE(MODE)) u_dec (
    .host_addr (host_addr),
    .hit_vec   (hit_vec),
    .offs      (offs)
  );

  pcimw_addr_form #(.MODE(MODE), .WW(WW)) u_form (
    .remap    (remap),
    .hit_vec  (hit_vec),
    .offs     (offs),
    .hit      (host_hit),
    .win      (host_win),
    .pci_addr (pci_addr)
  );

  // R1: decoded windows never overlap
  a_r1_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R1: the reported flag agrees with the decoder
  a_r1_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    host_hit == (hit_vec != '0));
  // R2: a miss leaves index and address at zero
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !host_hit |-> (pci_addr == '0 && host_win == '0));
endmodule

// File: tb/tb_pci_mem_window_xlat.sv
`timescale 1ns/1ps
module tb_pci_mem_window_xlat;
  import pcimw_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] ha_n, ha_m;
  logic [31:0] rd_n, rd_m, pa_n, pa_m;
  logic        hit_n, hit_m;
  logic [1:0]  win_n, win_m;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] model [3];

  always #10 clk = ~clk;

  pci_mem_window_xlat #(.MODE(MAP_NIBBLE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_n), .host_addr(ha_n),
    .host_hit(hit_n), .host_win(win_n), .pci_addr(pa_n));

  pci_mem_window_xlat #(.MODE(MAP_MASK)) dut_mask (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m), .host_addr(ha_m),
    .host_hit(hit_m), .host_win(win_m), .pci_addr(pa_m));

  // Reference register copy: cleared by reset, written on the edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) model[i] = 32'h0;
    end else if (cfg_we && cfg_addr[3:2] != 2'd3) begin
      model[cfg_addr[3:2]] = cfg_wdata;
    end
  end

  function automatic logic [31:0] hbase(bit m, int i);
    logic [31:0] nb [3] = '{32'h4400_0000, 32'h5000_0000, 32'h6000_0000};
    logic [31:0] mb [3] = '{32'h6300_0000, 32'h6400_0000, 32'h6800_0000};
    return m ? mb[i] : nb[i];
  endfunction

  function automatic logic [31:0] hsize(bit m, int i);
    logic [31:0] ns [3] = '{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000};
    logic [31:0] ms [3] = '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000};
    return m ? ms[i] : ns[i];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_one(bit m, logic [31:0] a, logic hit, logic [1:0] win,
                         logic [31:0] pa, logic [31:0] rd);
    bit          eh = 0;
    int          ew = 0;
    logic [31:0] ep = 32'h0;
    logic [31:0] er;
    for (int i = 0; i < 3; i++) begin
      longint lo = longint'(hbase(m, i));
      longint hi = lo + longint'(hsize(m, i));
      if (longint'(a) >= lo && longint'(a) < hi) begin
        logic [31:0] b;
        eh = 1; ew = i;
        if (m) b = model[i] & ~(hsize(m, i) - 32'h1);
        else   b = {model[i][3:0], 28'h0};
        ep = b + (a - hbase(m, i));
      end
    end
    chk(hit == eh, "R1", m ? "mask hit" : "nibble hit", {31'h0, hit}, {31'h0, eh});
    chk(win == 2'(ew), "R1", m ? "mask win" : "nibble win", {30'h0, win}, 32'(ew));
    if (!eh) chk(pa == 32'h0, "R2", "miss pci", pa, 32'h0);
    else if (m) chk(pa == ep, "R4", "mask pci", pa, ep);
    else chk(pa == ep, "R3", "nibble pci", pa, ep);
    if (cfg_addr[3:2] == 2'd3) begin
      chk(rd == 32'h0, "R5", "empty slot read", rd, 32'h0);
    end else begin
      er = model[cfg_addr[3:2]];
      chk(rd == er, "R8", "readback", rd, er);
    end
  endtask

  // Drive at the falling edge, judge a quarter period later (before the rising edge).
  task automatic step(logic we, logic [3:0] a, logic [31:0] d, logic [31:0] hn, logic [31:0] hm);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; ha_n = hn; ha_m = hm;
    #5;
    cmp_one(1'b0, ha_n, hit_n, win_n, pa_n, rd_n);
    cmp_one(1'b1, ha_m, hit_m, win_m, pa_m, rd_m);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 4'h0; cfg_wdata = 32'h0;
    ha_n = 32'h0; ha_m = 32'h0;
    do_reset();

    // R7: after reset each window passes its offset straight through
    step(0, 4'h0, 0, 32'h4400_0123, 32'h6300_0123);
    chk(pa_n == 32'h0000_0123, "R7", "nibble offset after reset", pa_n, 32'h0000_0123);
    chk(pa_m == 32'h0000_0123, "R7", "mask offset after reset", pa_m, 32'h0000_0123);
    step(0, 4'h8, 0, 32'h6FFF_FFFF, 32'h6FFF_FFFF);
    chk(pa_n == 32'h0FFF_FFFF, "R7", "nibble top after reset", pa_n, 32'h0FFF_FFFF);
    chk(pa_m == 32'h07FF_FFFF, "R7", "mask top after reset", pa_m, 32'h07FF_FFFF);

    // R8: program all three registers
    step(1, 4'h0, 32'hDEAD_BEE5, 32'h0, 32'h0);
    step(1, 4'h4, 32'h1234_5678, 32'h0, 32'h0);
    step(1, 4'h8, 32'hA5A5_A5AF, 32'h0, 32'h0);
    step(0, 4'h4, 0, 32'h0, 32'h0);
    chk(rd_n == 32'h1234_5678, "R8", "full readback nibble", rd_n, 32'h1234_5678);
    chk(rd_m == 32'h1234_5678, "R8", "full readback mask", rd_m, 32'h1234_5678);

    // R5: empty slot absorbs the write and reads zero
    step(1, 4'hC, 32'hFFFF_FFFF, 32'h0, 32'h0);
    step(0, 4'hC, 0, 32'h0, 32'h0);
    chk(rd_n == 32'h0, "R5", "slot 3 read", rd_n, 32'h0);
    step(0, 4'h8, 0, 32'h0, 32'h0);
    chk(rd_n == 32'hA5A5_A5AF, "R5", "slot 2 kept after slot 3 write", rd_n, 32'hA5A5_A5AF);

    // R6: write and translate window 1 in the same cycle
    step(1, 4'h4, 32'h0000_0007, 32'h5000_0010, 32'h6400_0010);
    chk(pa_n == 32'h8000_0010, "R6", "nibble old map in write cycle", pa_n, 32'h8000_0010);
    chk(pa_m == 32'h1000_0010, "R6", "mask old map in write cycle", pa_m, 32'h1000_0010);
    step(0, 4'h4, 0, 32'h5000_0010, 32'h6400_0010);
    chk(pa_n == 32'h7000_0010, "R6", "nibble new map next cycle", pa_n, 32'h7000_0010);
    chk(pa_m == 32'h0000_0010, "R6", "mask new map next cycle", pa_m, 32'h0000_0010);
    step(0, 4'h0, 0, 32'h4400_0000, 32'h6300_0000);
    chk(pa_n == 32'h5000_0000, "R6", "window 0 unchanged nibble", pa_n, 32'h5000_0000);
    chk(pa_m == 32'hDE00_0000, "R6", "window 0 unchanged mask", pa_m, 32'hDE00_0000);

    // R1/R2: both edges of every window
    for (int w = 0; w < 3; w++) begin
      step(0, 4'h0, 0, hbase(0, w) - 1, hbase(1, w) - 1);
      step(0, 4'h4, 0, hbase(0, w), hbase(1, w));
      step(0, 4'h8, 0, hbase(0, w) + hsize(0, w) - 1, hbase(1, w) + hsize(1, w) - 1);
      step(0, 4'h0, 0, hbase(0, w) + hsize(0, w), hbase(1, w) + hsize(1, w));
    end

    // Mixed random traffic, judged by the model each cycle
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] hn, hm;
      hn = ($urandom_range(0, 7) == 0) ? $urandom : (32'h4000_0000 | ($urandom & 32'h3FFF_FFFF));
      hm = ($urandom_range(0, 7) == 0) ? $urandom : (32'h6000_0000 | ($urandom & 32'h0FFF_FFFF));
      step($urandom_range(0, 9) < 3, 4'($urandom), $urandom, hn, hm);
    end

    // R7: a second reset clears programmed state
    do_reset();
    step(0, 4'h8, 0, 32'h6000_0040, 32'h6800_0040);
    chk(rd_n == 32'h0, "R7", "register cleared by reset", rd_n, 32'h0);
    chk(pa_n == 32'h0000_0040, "R7", "nibble offset after reset", pa_n, 32'h0000_0040);
    chk(pa_m == 32'h0000_0040, "R7", "mask offset after reset", pa_m, 32'h0000_0040);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule